// File: doc/BRIEF.md
# Run-Length Scanline Pattern Decoder

This block turns a compact byte stream into a full-screen serial pixel pattern that is mostly empty. The pattern is not held as a bitmap. The memory holds pairs of bytes. The first byte of a pair, the count byte, gives how many blank bytes to emit. The second byte, the pattern byte, is then shifted out one pixel per clock. A blank pixel is a 1, and a byte with no lit pixels is 0xFF. Because of this a screen of 32 bytes by 192 lines fits in a memory much smaller than 6144 bytes.

The memory sits outside the block and is read combinationally. The block drives `rom_addr` and takes `rom_data` back in the same cycle. A vertical-blank input rewinds the read pointer at the start of each frame. A byte strobe marks each 8-pixel byte period, and a pixel is produced on every clock. In reverse mode the memory is read from its top address downwards, and each loaded byte is shifted out least significant bit first. This lets a second encoding stored backwards draw the screen turned through 180 degrees.

Top module: `rle_line_pattern`

## Requirements
- R1: While `vblank` is high, on the next clock `rom_addr` becomes 0 (normal mode) or all ones (reverse mode, `rev` high), and `pix_out` becomes 1. Reset gives the normal-mode state.
- R2: The first byte read after `vblank` falls is a count byte. Its low 4 bits load the skip counter, and the number of blank bytes emitted before the next pattern byte is 15 minus that value.
- R3: A `byte_stb` edge at which the skip counter is at all ones loads the pattern byte at the current address. In normal mode its bit 7 appears on `pix_out` in the following cycle, and bits 6 down to 0 follow on the next seven clocks.
- R4: A `byte_stb` edge at which the skip counter is not all ones increments it, and the next 8 pixels are 1. This assumes strobes come every 8 clocks.
- R5: `rom_addr` changes only on two events: the cycle after a count-byte read, and a pattern load. It steps by +1 in normal mode and by -1 in reverse mode.
- R6: In reverse mode a loaded pattern byte is shifted out bit 0 first, then bits 1 to 7.
- R7: If bit 7 of a count byte is 0, the pattern byte that follows is shown fully blank.
- R8: A pair of two 0xFF bytes decodes as zero blank bytes followed by one all-blank byte, so 0xFF padding is harmless.
- R9: A whole 256x192 frame encoded this way decodes pixel-exact, both in normal mode and in reverse mode from a reversed encoding.
- R10: The address wraps from the last memory location to 0 (and from 0 to the last location in reverse mode), and decoding continues across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vblank | input | 1 | Frame restart; rewinds the read pointer |
| byte_stb | input | 1 | One-cycle strobe at the start of each 8-pixel byte period |
| rev | input | 1 | Reverse mode: read downwards, shift LSB first |
| rom_data | input | 8 | Combinational read data for `rom_addr` |
| rom_addr | output | ADDR_W (11) | Memory read address |
| pix_out | output | 1 | Serial pixel, 1 = blank |

## Verification
The hardest case to reach from the ports is the address wrap. It happens only after half the memory depth of pairs has been consumed, and the bytes read just after the wrap are the same ones that opened the frame. The stimulus fills the memory with zero-skip blank pairs and places distinct markers at the last location and at location 1. It then strobes more than 1024 byte periods, so the marker after the wrap must show up again. Full frames from a random sparse bitmap, encoded by the bench in both directions, cover long blank runs that need 16-byte filler pairs.

// File: rtl/rle_pkg.sv
package rle_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic reload_pend;  // next cycle reads a count byte
        logic kill;         // pending pattern byte forced blank
    } rle_ctl_t;
endpackage

// File: rtl/rle_skip_ctr.sv
module rle_skip_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    output logic             carry
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (load) cnt_d = load_val;
        else if (inc)  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign carry = &cnt_q;
endmodule

// File: rtl/rle_addr_gen.sv
module rle_addr_gen #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rev,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (clr)       addr_d = rev ? '1 : '0;
        else if (step) addr_d = rev ? addr_q - 1'b1 : addr_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;
endmodule

// File: rtl/rle_pix_shifter.sv
module rle_pix_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         blank,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         rev,
    output logic         bit_out
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (blank)     sh_d = '1;
        else if (load) sh_d = load_val;
        else if (rev)  sh_d = {1'b1, sh_q[W-1:1]};
        else           sh_d = {sh_q[W-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign bit_out = rev ? sh_q[0] : sh_q[W-1];
endmodule

// File: rtl/rle_line_pattern.sv
module rle_line_pattern
    import rle_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vblank,
    input  logic              byte_stb,
    input  logic              rev,
    input  logic [BYTE_W-1:0] rom_data,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              pix_out
);
    rle_ctl_t ctl_d, ctl_q;
    logic     skip_carry;
    logic     do_reload, do_load, do_skip;

    assign do_reload = ctl_q.reload_pend && !vblank;
    assign do_load   = byte_stb && skip_carry && !ctl_q.reload_pend && !vblank;
    assign do_skip   = byte_stb && !skip_carry && !ctl_q.reload_pend && !vblank;

    always_comb begin
        ctl_d = ctl_q;
        if (vblank) begin
            ctl_d.reload_pend = 1'b1;
            ctl_d.kill        = 1'b0;
        end else if (do_reload) begin
            ctl_d.reload_pend = 1'b0;
            ctl_d.kill        = !rom_data[BYTE_W-1];
        end else if (do_load) begin
            ctl_d.reload_pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{reload_pend: 1'b1, kill: 1'b0};
        else        ctl_q <= ctl_d;
    end

    rle_skip_ctr #(.CNT_W(CNT_W)) u_skip (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (vblank),
        .load     (do_reload),
        .load_val (rom_data[CNT_W-1:0]),
        .inc      (do_skip),
        .carry    (skip_carry)
    );

    rle_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (vblank),
        .rev   (rev),
        .step  (do_reload || do_load),
        .addr  (rom_addr)
    );

    rle_pix_shifter #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .blank    (vblank || (do_load && ctl_q.kill)),
        .load     (do_load),
        .load_val (rom_data),
        .rev      (rev),
        .bit_out  (pix_out)
    );
endmodule

// File: rtl/rle_line_pattern_chk.sv
module rle_line_pattern_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vblank,
    input logic              byte_stb,
    input logic              rev,
    input logic [7:0]        rom_data,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              pix_out,
    input logic              carry,
    input logic              reload_pend,
    input logic              kill
);
    AST_VBL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        vblank |=> rom_addr == ($past(rev) ? {ADDR_W{1'b1}} : {ADDR_W{1'b0}})); // R1
    AST_VBL_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        vblank |=> pix_out); // R1
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!vblank && !reload_pend && !(byte_stb && carry)) |=> $stable(rom_addr)); // R5
    AST_ADDR_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (!vblank && (reload_pend || (byte_stb && carry)))
        |=> rom_addr == ($past(rev) ? ADDR_W'($past(rom_addr) - 1) : ADDR_W'($past(rom_addr) + 1))); // R5
    AST_SKIP_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !carry && !reload_pend && !vblank) |=> pix_out); // R4
    AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && carry && !reload_pend && !vblank && !kill)
        |=> pix_out == ($past(rev) ? $past(rom_data[0]) : $past(rom_data[7]))); // R3
    AST_KILL_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && carry && !reload_pend && !vblank && kill) |=> pix_out); // R7
endmodule

bind rle_line_pattern rle_line_pattern_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vblank      (vblank),
    .byte_stb    (byte_stb),
    .rev         (rev),
    .rom_data    (rom_data),
    .rom_addr    (rom_addr),
    .pix_out     (pix_out),
    .carry       (skip_carry),
    .reload_pend (ctl_q.reload_pend),
    .kill        (ctl_q.kill)
);

// File: tb/tb_rle_line_pattern.sv
module tb_rle_line_pattern;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 11;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int NBYTES     = 32 * 192;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              vblank = 1'b0;
    logic              byte_stb = 1'b0;
    logic              rev = 1'b0;
    logic [7:0]        rom_data;
    logic [ADDR_W-1:0] rom_addr;
    logic              pix_out;

    logic [7:0] rom [0:DEPTH-1];
    logic [7:0] bm  [0:NBYTES-1];
    logic [7:0] got [0:NBYTES-1];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign rom_data = rom[rom_addr];

    rle_line_pattern #(.ADDR_W(ADDR_W), .CNT_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .vblank(vblank), .byte_stb(byte_stb),
        .rev(rev), .rom_data(rom_data), .rom_addr(rom_addr), .pix_out(pix_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("[TB] FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bitrev(input logic [7:0] v);
        for (int i = 0; i < 8; i++) bitrev[i] = v[7-i];
    endfunction

    task automatic rom_fill();
        for (int i = 0; i < DEPTH; i++) rom[i] = 8'hFF;
    endtask

    // Rewind; R1 checked after the vblank edge, R5 after the count read.
    task automatic start_frame(input bit r);
        @(negedge clk); vblank = 1'b1; rev = r;
        @(negedge clk); vblank = 1'b0;
        chk(rom_addr == (r ? ADDR_W'(DEPTH-1) : ADDR_W'(0)), "R1 addr after vblank", rom_addr, r ? DEPTH-1 : 0);
        chk(pix_out == 1'b1, "R1 blank after vblank", pix_out, 1);
        @(negedge clk);
        chk(rom_addr == (r ? ADDR_W'(DEPTH-2) : ADDR_W'(1)), "R5 step after count read", rom_addr, r ? DEPTH-2 : 1);
    endtask

    // One strobe every 8 clocks; gather pixels in arrival order, first in bit 7.
    task automatic run_bytes(input int n);
        logic [7:0] v;
        for (int i = 0; i < n; i++) begin
            byte_stb = 1'b1;
            @(negedge clk); byte_stb = 1'b0;
            v[7] = pix_out;
            for (int k = 6; k >= 0; k--) begin
                @(negedge clk); v[k] = pix_out;
            end
            got[i] = v;
        end
    endtask

    task automatic t_reset();
        chk(rom_addr == '0, "R1 reset addr", rom_addr, 0);
        chk(pix_out == 1'b1, "R1 reset pixel", pix_out, 1);
    endtask

    task automatic t_basic();
        rom_fill();
        rom[0] = 8'hFD; rom[1] = 8'hA5; rom[2] = 8'hFF; rom[3] = 8'h3C;
        start_frame(1'b0);
        run_bytes(5);
        chk(got[0] == 8'hFF && got[1] == 8'hFF, "R2 two blank bytes", {got[0], got[1]}, 16'hFFFF);
        chk(got[2] == 8'hA5, "R3 pattern msb first", got[2], 8'hA5);
        chk(got[3] == 8'h3C, "R3 back-to-back pattern", got[3], 8'h3C);
        chk(got[4] == 8'hFF, "R4 padding blank", got[4], 8'hFF);
        chk(rom_addr == ADDR_W'(7), "R5 address count", rom_addr, 7);
    endtask

    task automatic t_kill();
        rom_fill();
        rom[0] = 8'h7F; rom[1] = 8'h00; rom[2] = 8'hFF; rom[3] = 8'h0F;
        start_frame(1'b0);
        run_bytes(2);
        chk(got[0] == 8'hFF, "R7 disabled pattern blank", got[0], 8'hFF);
        chk(got[1] == 8'h0F, "R7 enable restored", got[1], 8'h0F);
    endtask

    task automatic t_ffpair();
        rom_fill();
        rom[3] = 8'h81;
        start_frame(1'b0);
        run_bytes(2);
        chk(got[0] == 8'hFF, "R8 FF pair one blank byte", got[0], 8'hFF);
        chk(got[1] == 8'h81, "R8 next pair immediate", got[1], 8'h81);
    endtask

    task automatic t_rev_small();
        rom_fill();
        rom[DEPTH-1] = 8'hFE; rom[DEPTH-2] = 8'h12;
        rom[DEPTH-3] = 8'hFF; rom[DEPTH-4] = 8'h80;
        start_frame(1'b1);
        run_bytes(3);
        chk(got[0] == 8'hFF, "R2 reverse one blank", got[0], 8'hFF);
        chk(got[1] == bitrev(8'h12), "R6 lsb first", got[1], bitrev(8'h12));
        chk(got[2] == bitrev(8'h80), "R6 lsb first second", got[2], bitrev(8'h80));
        chk(rom_addr == ADDR_W'(DEPTH-6), "R5 reverse stepping", rom_addr, DEPTH-6);
    endtask

    task automatic t_wrap();
        rom_fill();
        rom[1] = 8'hC3; rom[DEPTH-1] = 8'h5A;
        start_frame(1'b0);
        run_bytes(DEPTH/2 + 1);
        chk(got[0] == 8'hC3, "R10 first pattern", got[0], 8'hC3);
        chk(got[500] == 8'hFF, "R10 middle blank", got[500], 8'hFF);
        chk(got[DEPTH/2-1] == 8'h5A, "R10 last location", got[DEPTH/2-1], 8'h5A);
        chk(got[DEPTH/2] == 8'hC3, "R10 after wrap", got[DEPTH/2], 8'hC3);
        chk(rom_addr == ADDR_W'(3), "R10 address wrapped", rom_addr, 3);
    endtask

    task automatic build_rom(input bit r);
        int k, run;
        logic [7:0] b;
        rom_fill();
        k = 0; run = 0;
        for (int j = 0; j < NBYTES; j++) begin
            b = r ? bm[NBYTES-1-j] : bm[j];
            if (b == 8'hFF) run++;
            else begin
                while (run >= 16) begin
                    if (r) begin rom[DEPTH-1-k] = 8'hF0; rom[DEPTH-2-k] = 8'hFF; end
                    else   begin rom[k] = 8'hF0; rom[k+1] = 8'hFF; end
                    k += 2; run -= 16;
                end
                if (r) begin rom[DEPTH-1-k] = 8'hF0 | 8'(15-run); rom[DEPTH-2-k] = b; end
                else   begin rom[k] = 8'hF0 | 8'(15-run); rom[k+1] = b; end
                k += 2; run = 0;
            end
        end
        chk(k <= DEPTH, "R9 encoding fits", k, DEPTH);
    endtask

    task automatic t_frame(input bit r);
        int bad;
        logic [7:0] e;
        build_rom(r);
        start_frame(r);
        run_bytes(NBYTES);
        bad = 0;
        for (int j = 0; j < NBYTES; j++) begin
            e = r ? bitrev(bm[NBYTES-1-j]) : bm[j];
            for (int i = 0; i < 8; i++) if (got[j][i] != e[i]) bad++;
        end
        chk(bad == 0, r ? "R9 reverse frame mismatched pixels" : "R9 normal frame mismatched pixels", bad, 0);
    endtask

    initial begin
        for (int j = 0; j < NBYTES; j++)
            bm[j] = ($urandom_range(0, 15) == 0) ? 8'($urandom_range(0, 254)) : 8'hFF;
        rom_fill();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_kill();
        t_ffpair();
        t_rev_small();
        t_wrap();
        t_frame(1'b0);
        t_frame(1'b1);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("[TB] FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule